// File: doc/BRIEF.md
# CDS Pixel Readout Timing Generator

This block produces the control waveforms that read one frame of a 16 by 16 storage-pixel image sensor through a correlated double sampling (CDS) chain. A single-cycle start request in the idle state launches a full frame. The frame is walked pixel by pixel, and sixteen pixels make a row.

For every pixel the block does the following, in order:

- It pulses the reset gate.
- It opens the ADC gate and issues four reset-level sample clocks.
- It moves the stored charge onto the sense node by stepping three CCD phases one after another.
- It issues four signal-level sample clocks.
- It pulses the column multiplexer advance, so the next column is interleaved onto the single analog output.

Downstream logic subtracts each pixel's reset group from its signal group. The block reports its current column and row, holds a busy flag for the whole frame, and pulses done when the last pixel of the last row is finished.

Top module: `cds_readout_timing`

## Requirements
- R1: While reset is held and in the first cycle after it, every control output, busy and done are low, and the column and row outputs are 0.
- R2: A start sampled high while idle raises busy and the reset gate in the next cycle. The reset gate stays high for exactly 2 cycles, while the ADC gate is low.
- R3: Each pixel spans 22 cycles, counted as offsets 0 to 21 from its first reset-gate cycle. The ADC gate is high continuously from offset 2 to offset 20 and low at offsets 0, 1 and 21.
- R4: The ADC clock is high at offsets 2, 4, 6 and 8 (the four reset samples) and at 13, 15, 17 and 19 (the four signal samples). It is low at every other offset and is never high while the ADC gate is low.
- R5: Phase 1 is high at offset 10 only, phase 2 at offset 11 only, and phase 3 at offset 12 only. No two phases are ever high together.
- R6: The multiplexer advance is high for exactly one cycle per pixel, at offset 21. All other control outputs are low in that cycle.
- R7: The column output equals the pixel's index within its row (0 to 15) throughout the pixel. The row output advances by one after column 15 and the column returns to 0.
- R8: After the 256th pixel's multiplexer advance (5632 cycles after the frame begins), done is high for exactly one cycle. Busy and all control outputs are low from that cycle on.
- R9: A start request while busy is ignored: the frame's waveform, column, row and length are unchanged.
- R10: Reset asserted in the middle of a frame returns the block to idle, with all outputs low and column and row at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request, accepted only when idle |
| rst_gate_o | output | 1 | Sensor reset-gate pulse |
| ph1_o | output | 1 | CCD phase 1 |
| ph2_o | output | 1 | CCD phase 2 |
| ph3_o | output | 1 | CCD phase 3 |
| adc_gate_o | output | 1 | ADC acquisition window |
| adc_clk_o | output | 1 | ADC sample clock, one pulse per sample |
| mux_adv_o | output | 1 | Column multiplexer advance |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| col_o | output | 4 | Current column index |
| row_o | output | 4 | Current row index |

## Verification
The hardest condition to reach is the end of the frame. The row-and-column wrap that ends the frame happens only after 255 full pixels. At that point a wrong wrap, a missing done pulse or an extra pixel shows up only as a shifted cycle count.

The stimulus therefore runs an entire 5632-cycle frame. It compares every cycle against a 22-entry per-pixel pattern and checks column and row at every pixel boundary. It also injects a start request in the middle of the frame, so that acceptance while busy would corrupt the otherwise exact alignment. Reset in the middle of a frame is tested on a second frame.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RG,
    ST_RSMP,
    ST_PH1,
    ST_PH2,
    ST_PH3,
    ST_SSMP,
    ST_ADV
  } cds_state_e;

  typedef struct packed {
    logic rg;
    logic ph1;
    logic ph2;
    logic ph3;
    logic gate;
    logic sclk;
    logic adv;
  } cds_pins_t;

endpackage

// File: rtl/cds_loop_cnt.sv
module cds_loop_cnt #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == W'(N - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= W'(N - 1)) else $error("count out of range"); // R7

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc_i && last_o && !clr_i) |=> (cnt_q == '0)) else $error("wrap missed"); // R7

endmodule

// File: rtl/cds_pixel_fsm.sv
module cds_pixel_fsm
  import cds_pkg::*;
#(
  parameter int RG_CYC = 2,
  parameter int N_RST  = 4,
  parameter int N_SIG  = 4,
  parameter int PH_CYC = 1,
  localparam int LEN_R = 2 * N_RST,
  localparam int LEN_S = 2 * N_SIG,
  localparam int LMAX  = (LEN_R > LEN_S) ? ((LEN_R > RG_CYC) ? LEN_R : RG_CYC)
                                         : ((LEN_S > RG_CYC) ? LEN_S : RG_CYC),
  localparam int LTOP  = (LMAX > PH_CYC) ? LMAX : PH_CYC,
  localparam int CW    = $clog2(LTOP + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start_i,
  input  logic      more_i,
  output cds_pins_t pins_o,
  output logic      busy_o,
  output logic      done_o,
  output logic      launch_o,
  output logic      pix_end_o
);

  cds_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cds_pins_t pins_q, pins_d;
  logic busy_q, done_q;

  function automatic logic [CW-1:0] last_of(cds_state_e s);
    case (s)
      ST_RG:                 return CW'(RG_CYC - 1);
      ST_RSMP:               return CW'(LEN_R - 1);
      ST_PH1, ST_PH2, ST_PH3: return CW'(PH_CYC - 1);
      ST_SSMP:               return CW'(LEN_S - 1);
      default:               return '0;
    endcase
  endfunction

  function automatic cds_state_e next_of(cds_state_e s, logic more);
    case (s)
      ST_RG:   return ST_RSMP;
      ST_RSMP: return ST_PH1;
      ST_PH1:  return ST_PH2;
      ST_PH2:  return ST_PH3;
      ST_PH3:  return ST_SSMP;
      ST_SSMP: return ST_ADV;
      ST_ADV:  return more ? ST_RG : ST_IDLE;
      default: return ST_IDLE;
    endcase
  endfunction

  wire seg_end = (st_q != ST_IDLE) && (cnt_q == last_of(st_q));

  assign launch_o  = (st_q == ST_IDLE) && start_i;
  assign pix_end_o = (st_q == ST_ADV) && seg_end;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (st_q == ST_IDLE) begin
      if (start_i) begin
        st_d  = ST_RG;
        cnt_d = '0;
      end
    end else if (seg_end) begin
      st_d  = next_of(st_q, more_i);
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    pins_d      = '0;
    pins_d.rg   = (st_d == ST_RG);
    pins_d.ph1  = (st_d == ST_PH1);
    pins_d.ph2  = (st_d == ST_PH2);
    pins_d.ph3  = (st_d == ST_PH3);
    pins_d.gate = (st_d == ST_RSMP) || (st_d == ST_PH1) || (st_d == ST_PH2) ||
                  (st_d == ST_PH3) || (st_d == ST_SSMP);
    pins_d.sclk = ((st_d == ST_RSMP) || (st_d == ST_SSMP)) && !cnt_d[0];
    pins_d.adv  = (st_d == ST_ADV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pins_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pins_q <= pins_d;
      busy_q <= (st_d != ST_IDLE);
      done_q <= pix_end_o && !more_i;
    end
  end

  assign pins_o = pins_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pins_q.ph1, pins_q.ph2, pins_q.ph3})) else $error("phase overlap"); // R5

  AST_PH1_TO_PH2: assert property (@(posedge clk) disable iff (rst)
    $fell(pins_q.ph1) |-> pins_q.ph2) else $error("phase 2 late"); // R5

  AST_PH2_TO_PH3: assert property (@(posedge clk) disable iff (rst)
    $fell(pins_q.ph2) |-> pins_q.ph3) else $error("phase 3 late"); // R5

  AST_SCLK_IN_GATE: assert property (@(posedge clk) disable iff (rst)
    pins_q.sclk |-> pins_q.gate) else $error("sample outside gate"); // R4

  AST_PH3_TO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $fell(pins_q.ph3) |-> pins_q.sclk) else $error("signal sample late"); // R4

  AST_RG_TO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    $fell(pins_q.rg) |-> (pins_q.gate && pins_q.sclk)) else $error("reset sample late"); // R3

  AST_ADV_PULSE: assert property (@(posedge clk) disable iff (rst)
    pins_q.adv |=> !pins_q.adv) else $error("advance too long"); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && pins_q == '0)) else $error("done while active"); // R8

endmodule

// File: rtl/cds_readout_timing.sv
module cds_readout_timing
  import cds_pkg::*;
#(
  parameter int N_COLS = 16,
  parameter int N_ROWS = 16,
  parameter int RG_CYC = 2,
  parameter int N_RST  = 4,
  parameter int N_SIG  = 4,
  parameter int PH_CYC = 1,
  localparam int COL_W = $clog2(N_COLS),
  localparam int ROW_W = $clog2(N_ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             rst_gate_o,
  output logic             ph1_o,
  output logic             ph2_o,
  output logic             ph3_o,
  output logic             adc_gate_o,
  output logic             adc_clk_o,
  output logic             mux_adv_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o
);

  cds_pins_t pins;
  logic launch, pix_end, col_last, row_last, more;

  assign more = !(col_last && row_last);

  cds_pixel_fsm #(
    .RG_CYC(RG_CYC), .N_RST(N_RST), .N_SIG(N_SIG), .PH_CYC(PH_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .more_i    (more),
    .pins_o    (pins),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .launch_o  (launch),
    .pix_end_o (pix_end)
  );

  cds_loop_cnt #(.N(N_COLS)) u_col (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (launch),
    .inc_i  (pix_end),
    .cnt_o  (col_o),
    .last_o (col_last)
  );

  cds_loop_cnt #(.N(N_ROWS)) u_row (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (launch),
    .inc_i  (pix_end && col_last),
    .cnt_o  (row_o),
    .last_o (row_last)
  );

  assign rst_gate_o = pins.rg;
  assign ph1_o      = pins.ph1;
  assign ph2_o      = pins.ph2;
  assign ph3_o      = pins.ph3;
  assign adc_gate_o = pins.gate;
  assign adc_clk_o  = pins.sclk;
  assign mux_adv_o  = pins.adv;

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !mux_adv_o) |=> $stable(col_o)) else $error("start disturbed frame"); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !(rst_gate_o || adc_gate_o || mux_adv_o)) else $error("activity while idle"); // R1

endmodule

// File: tb/cds_readout_timing_bench.sv
module cds_readout_timing_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_LEN    = 22;
  localparam int N_PIX      = 256;
  localparam int FRAME_LEN  = PIX_LEN * N_PIX;

  // per-pixel expected pattern {rg, ph1, ph2, ph3, gate, sclk, adv}
  localparam logic [6:0] EXP [PIX_LEN] = '{
    7'b1000000, 7'b1000000,
    7'b0000110, 7'b0000100, 7'b0000110, 7'b0000100,
    7'b0000110, 7'b0000100, 7'b0000110, 7'b0000100,
    7'b0100100, 7'b0010100, 7'b0001100,
    7'b0000110, 7'b0000100, 7'b0000110, 7'b0000100,
    7'b0000110, 7'b0000100, 7'b0000110, 7'b0000100,
    7'b0000001
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rg, p1, p2, p3, gate, sclk, adv, busy, done;
  logic [3:0] col, row;
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cds_readout_timing u_cds_readout_timing (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .rst_gate_o (rg),
    .ph1_o      (p1),
    .ph2_o      (p2),
    .ph3_o      (p3),
    .adc_gate_o (gate),
    .adc_clk_o  (sclk),
    .mux_adv_o  (adv),
    .busy_o     (busy),
    .done_o     (done),
    .col_o      (col),
    .row_o      (row)
  );

  wire [6:0] pins = {rg, p1, p2, p3, gate, sclk, adv};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pins in reset", pins, 0);
    chk("R1 busy/done in reset", {busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pins after reset", pins, 0);
    chk("R1 col/row after reset", {col, row}, 0);
    chk("R1 busy after reset", {busy, done}, 0);

    // full frame walked against the per-pixel table
    start = 1'b1;
    @(negedge clk);
    for (int t = 0; t < FRAME_LEN; t++) begin
      // R9: start request raised once mid-frame
      start = (t == 50);
      chk("R2-R6 waveform", pins, EXP[t % PIX_LEN]);
      chk("R2 busy", busy, 1);
      if (t % PIX_LEN == 0) begin
        chk("R7 col", col, (t / PIX_LEN) % 16);
        chk("R7 row", row, (t / PIX_LEN) / 16);
      end
      @(negedge clk);
    end
    chk("R8 done pulse", done, 1);
    chk("R8 busy low at done", busy, 0);
    chk("R8 pins low at done", pins, 0);
    chk("R9 frame length unchanged, col wrapped", {col, row}, 0);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R8 stays idle", {busy, pins}, 0);

    // second frame, reset in the middle
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 restart reset gate", pins, EXP[0]);
    repeat (PIX_LEN * 3 + 5) @(negedge clk);
    chk("R7 col in second frame", col, 3);
    chk("R3 mid-pixel pattern", pins, EXP[5]);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 pins after mid reset", pins, 0);
    chk("R10 busy after mid reset", {busy, done}, 0);
    chk("R10 col/row after mid reset", {col, row}, 0);
    repeat (4) @(negedge clk);
    chk("R10 stays idle", {busy, pins}, 0);
    summary();
  end

endmodule